// File: doc/BRIEF.md
# Banked Matrix Vector Register File

This block is a register file of single-precision words. Its registers are grouped into square matrix banks. With the default parameters there are eight banks of 4x4, 128 words in all. Every register has one flat index, and any group of registers that lies inside one bank can be reached in five ways: as a lone scalar, as a row vector, as a column vector, as a square matrix, or as a transposed square matrix. A vector carries two to four components, and a matrix is 2x2, 3x3 or 4x4.

The file has two read ports and one write port. Each port gives a bank, a start row, a start column, a shape code and a component count. Reads gather the addressed words onto a packed bus of sixteen 32-bit lanes. Lane k sits in bits [32k+31:32k], and the lanes that the shape does not use read as zero. A write scatters the same lanes back into the file. Any request that leaves its bank, or that has a count or shape code the file does not accept, raises that port's range-error flag. Reads are combinational, and a write commits on the rising clock edge.

Top module: `vrf_matrix_file`

## Requirements
- R1: After an active-low reset, every register reads as zero.
- R2: The element at row r, column c of bank b is flat register 32*r + 4*b + c. Each register is the same storage under every shape that reaches it.
- R3: Shape code 0 (scalar) returns element (row, col) in lane 0. All other lanes read zero, and the count input has no effect.
- R4: Shape code 1 (row vector) with count n puts element (row, col+k) in lane k, for k < n.
- R5: Shape code 2 (column vector) with count n puts element (row+k, col) in lane k, for k < n.
- R6: Shape code 3 (matrix) with count n puts element (row+i, col+j) in lane 4*i + j, for i, j < n.
- R7: Shape code 4 (transposed matrix) with count n puts element (row+j, col+i) in lane 4*i + j, for i, j < n.
- R8: Lanes that the shape and count do not cover read as zero. On a write, the data in those lanes is ignored and the registers they would map to keep their values.
- R9: The range-error flag is set when any of these holds: the shape code is 5 to 7; the shape is not scalar and the count is outside 2..4; or the last addressed row or column is past index 3. While the flag is set, the port reads all zeros.
- R10: A write whose range-error flag is set changes no register.
- R11: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the value it held before that edge.
- R12: The two read ports are independent. Each port returns its own request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every register |
| ra_bank | input | 3 | Read port A bank number |
| ra_row | input | 2 | Read port A start row |
| ra_col | input | 2 | Read port A start column |
| ra_shape | input | 3 | Read port A shape code (0 scalar, 1 row, 2 column, 3 matrix, 4 transposed) |
| ra_count | input | 3 | Read port A component count |
| ra_data | output | 512 | Read port A lane bus, 16 lanes of 32 bits |
| ra_err | output | 1 | Read port A range error |
| rb_bank | input | 3 | Read port B bank number |
| rb_row | input | 2 | Read port B start row |
| rb_col | input | 2 | Read port B start column |
| rb_shape | input | 3 | Read port B shape code |
| rb_count | input | 3 | Read port B component count |
| rb_data | output | 512 | Read port B lane bus |
| rb_err | output | 1 | Read port B range error |
| wr_en | input | 1 | Write request |
| wr_bank | input | 3 | Write bank number |
| wr_row | input | 2 | Write start row |
| wr_col | input | 2 | Write start column |
| wr_shape | input | 3 | Write shape code |
| wr_count | input | 3 | Write component count |
| wr_data | input | 512 | Write lane bus |
| wr_err | output | 1 | Write range error; when set, the write is dropped |

## Verification
The bench builds the file with its default parameters: eight banks of 4x4 words, 32 bits each. It also uses a 3-bit count, which can carry the illegal values 0, 1 and 5 to 7 as well as the legal 2 to 4. These values make every shape, every start position and the complete 4x4 transposed access reachable, together with the row stride of 32 that ties the banks together. Random writes and reads on both read ports let accesses of different shapes overlap in the same registers. Directed cases cover the examples quoted in the requirements, dropped writes that overrun a bank, and reads of a register in the cycle it is written.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  typedef enum logic [2:0] {
    SHP_SCALAR = 3'd0,
    SHP_ROW    = 3'd1,
    SHP_COL    = 3'd2,
    SHP_MAT    = 3'd3,
    SHP_TMAT   = 3'd4
  } vrf_shape_e;

  // Where one lane lands relative to the start element of an access.
  typedef struct packed {
    logic hit;
    int   dr;
    int   dc;
  } lane_pos_t;

  // li, lj: row and column of the lane slot in the square lane layout.
  function automatic lane_pos_t lane_place(input vrf_shape_e shp, input int n,
                                           input int li, input int lj);
    lane_pos_t p;
    p = '0;
    case (shp)
      SHP_SCALAR: p.hit = (li == 0) && (lj == 0);
      SHP_ROW: begin
        p.hit = (li == 0) && (lj < n);
        p.dc  = lj;
      end
      SHP_COL: begin
        p.hit = (li == 0) && (lj < n);
        p.dr  = lj;
      end
      SHP_MAT: begin
        p.hit = (li < n) && (lj < n);
        p.dr  = li;
        p.dc  = lj;
      end
      SHP_TMAT: begin
        p.hit = (li < n) && (lj < n);
        p.dr  = lj;
        p.dc  = li;
      end
      default: p.hit = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/vrf_addr_gen.sv
module vrf_addr_gen #(
  parameter int NUM_BANKS = 8,
  parameter int DIM       = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int POS_W     = $clog2(DIM),
  parameter int CNT_W     = $clog2(DIM) + 1,
  parameter int IDX_W     = $clog2(NUM_BANKS * DIM * DIM)
) (
  input  logic [BANK_W-1:0]          bank,
  input  logic [POS_W-1:0]           row,
  input  logic [POS_W-1:0]           col,
  input  logic [2:0]                 shape,
  input  logic [CNT_W-1:0]           count,
  output logic [DIM*DIM*IDX_W-1:0]   lane_idx,
  output logic [DIM*DIM-1:0]         lane_en,
  output logic                       range_err
);
  import vrf_pkg::*;

  localparam int LANES      = DIM * DIM;
  localparam int ROW_STRIDE = NUM_BANKS * DIM;

  function automatic int flat_of(input int r, input int c, input int b);
    return r * ROW_STRIDE + b * DIM + c;
  endfunction

  vrf_shape_e shape_e;
  int         n_eff;
  int         ext_r;
  int         ext_c;
  logic       bad_req;

  assign shape_e = vrf_shape_e'(shape);

  always_comb begin
    n_eff   = int'(count);
    ext_r   = 1;
    ext_c   = 1;
    bad_req = 1'b0;
    case (shape_e)
      SHP_SCALAR: n_eff = 1;
      SHP_ROW:    ext_c = n_eff;
      SHP_COL:    ext_r = n_eff;
      SHP_MAT, SHP_TMAT: begin
        ext_r = n_eff;
        ext_c = n_eff;
      end
      default: bad_req = 1'b1;
    endcase
    if (shape_e != SHP_SCALAR && (n_eff < 2 || n_eff > DIM)) bad_req = 1'b1;
    range_err = bad_req || (int'(row) + ext_r > DIM) || (int'(col) + ext_c > DIM);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LI = l / DIM;
    localparam int LJ = l % DIM;
    lane_pos_t pos;
    assign pos = lane_place(shape_e, n_eff, LI, LJ);
    assign lane_en[l] = pos.hit & ~range_err;
    assign lane_idx[l*IDX_W +: IDX_W] =
      IDX_W'(flat_of(int'(row) + pos.dr, int'(col) + pos.dc, int'(bank)));
  end

endmodule

// File: rtl/vrf_gather.sv
module vrf_gather #(
  parameter int WORD_W   = 32,
  parameter int NUM_REGS = 128,
  parameter int LANES    = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [WORD_W-1:0]        regs [NUM_REGS],
  input  logic [LANES*IDX_W-1:0]   lane_idx,
  input  logic [LANES-1:0]         lane_en,
  output logic [LANES*WORD_W-1:0]  data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data[l*WORD_W +: WORD_W] =
      lane_en[l] ? regs[lane_idx[l*IDX_W +: IDX_W]] : '0;
  end

endmodule

// File: rtl/vrf_storage.sv
module vrf_storage #(
  parameter int WORD_W   = 32,
  parameter int NUM_REGS = 128,
  parameter int LANES    = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [LANES*IDX_W-1:0]   lane_idx,
  input  logic [LANES-1:0]         lane_en,
  input  logic [LANES*WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]        regs [NUM_REGS]
);

  logic [WORD_W-1:0] mem [NUM_REGS];

  // Lanes of one legal access map to distinct registers, so the loop
  // never writes one register twice.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) mem[lane_idx[l*IDX_W +: IDX_W]] <= wdata[l*WORD_W +: WORD_W];
      end
    end
  end

  assign regs = mem;

endmodule

// File: rtl/vrf_matrix_file.sv
module vrf_matrix_file #(
  parameter int NUM_BANKS = 8,
  parameter int DIM       = 4,
  parameter int WORD_W    = 32,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int POS_W     = $clog2(DIM),
  parameter int CNT_W     = $clog2(DIM) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BANK_W-1:0]           ra_bank,
  input  logic [POS_W-1:0]            ra_row,
  input  logic [POS_W-1:0]            ra_col,
  input  logic [2:0]                  ra_shape,
  input  logic [CNT_W-1:0]            ra_count,
  output logic [DIM*DIM*WORD_W-1:0]   ra_data,
  output logic                        ra_err,
  input  logic [BANK_W-1:0]           rb_bank,
  input  logic [POS_W-1:0]            rb_row,
  input  logic [POS_W-1:0]            rb_col,
  input  logic [2:0]                  rb_shape,
  input  logic [CNT_W-1:0]            rb_count,
  output logic [DIM*DIM*WORD_W-1:0]   rb_data,
  output logic                        rb_err,
  input  logic                        wr_en,
  input  logic [BANK_W-1:0]           wr_bank,
  input  logic [POS_W-1:0]            wr_row,
  input  logic [POS_W-1:0]            wr_col,
  input  logic [2:0]                  wr_shape,
  input  logic [CNT_W-1:0]            wr_count,
  input  logic [DIM*DIM*WORD_W-1:0]   wr_data,
  output logic                        wr_err
);

  localparam int LANES    = DIM * DIM;
  localparam int NUM_REGS = NUM_BANKS * LANES;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic [WORD_W-1:0]      regs [NUM_REGS];
  logic [LANES*IDX_W-1:0] ra_idx, rb_idx, wr_idx;
  logic [LANES-1:0]       ra_en, rb_en, wr_lane_en;
  logic                   wr_commit;

  vrf_addr_gen #(.NUM_BANKS(NUM_BANKS), .DIM(DIM), .BANK_W(BANK_W), .POS_W(POS_W),
                 .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ag_a (
    .bank(ra_bank), .row(ra_row), .col(ra_col), .shape(ra_shape), .count(ra_count),
    .lane_idx(ra_idx), .lane_en(ra_en), .range_err(ra_err));

  vrf_addr_gen #(.NUM_BANKS(NUM_BANKS), .DIM(DIM), .BANK_W(BANK_W), .POS_W(POS_W),
                 .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ag_b (
    .bank(rb_bank), .row(rb_row), .col(rb_col), .shape(rb_shape), .count(rb_count),
    .lane_idx(rb_idx), .lane_en(rb_en), .range_err(rb_err));

  vrf_addr_gen #(.NUM_BANKS(NUM_BANKS), .DIM(DIM), .BANK_W(BANK_W), .POS_W(POS_W),
                 .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ag_w (
    .bank(wr_bank), .row(wr_row), .col(wr_col), .shape(wr_shape), .count(wr_count),
    .lane_idx(wr_idx), .lane_en(wr_lane_en), .range_err(wr_err));

  // Named commit event for the checker.
  assign wr_commit = wr_en & ~wr_err;

  vrf_storage #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .LANES(LANES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .lane_idx(wr_idx), .lane_en(wr_lane_en),
    .wdata(wr_data), .regs(regs));

  vrf_gather #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .LANES(LANES), .IDX_W(IDX_W)) u_rd_a (
    .regs(regs), .lane_idx(ra_idx), .lane_en(ra_en), .data(ra_data));

  vrf_gather #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .LANES(LANES), .IDX_W(IDX_W)) u_rd_b (
    .regs(regs), .lane_idx(rb_idx), .lane_en(rb_en), .data(rb_data));

endmodule

// File: rtl/vrf_matrix_file_chk.sv
module vrf_matrix_file_chk #(
  parameter int WORD_W = 32,
  parameter int LANES  = 16,
  parameter int BANK_W = 3,
  parameter int POS_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [BANK_W-1:0]         ra_bank,
  input logic [POS_W-1:0]          ra_row,
  input logic [POS_W-1:0]          ra_col,
  input logic [2:0]                ra_shape,
  input logic [CNT_W-1:0]          ra_count,
  input logic [LANES*WORD_W-1:0]   ra_data,
  input logic                      ra_err,
  input logic [LANES*WORD_W-1:0]   rb_data,
  input logic                      rb_err,
  input logic                      wr_commit,
  input logic [BANK_W-1:0]         wr_bank,
  input logic [POS_W-1:0]          wr_row,
  input logic [POS_W-1:0]          wr_col,
  input logic [2:0]                wr_shape,
  input logic [LANES*WORD_W-1:0]   wr_data
);

  AST_ERR_READS_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
    ra_err |-> (ra_data == '0)); // R9

  AST_ERR_READS_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
    rb_err |-> (rb_data == '0)); // R9

  AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_shape == 3'd0 && !ra_err) |-> (ra_data[LANES*WORD_W-1:WORD_W] == '0)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_commit) && $past(wr_shape) == 3'd0 && ra_shape == 3'd0 &&
     ra_bank == $past(wr_bank) && ra_row == $past(wr_row) && ra_col == $past(wr_col))
    |-> (ra_data[WORD_W-1:0] == $past(wr_data[WORD_W-1:0]))); // R11

  AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_commit) && $stable(ra_bank) && $stable(ra_row) &&
     $stable(ra_col) && $stable(ra_shape) && $stable(ra_count))
    |-> $stable(ra_data)); // R10

endmodule

bind vrf_matrix_file vrf_matrix_file_chk #(
  .WORD_W(WORD_W), .LANES(LANES), .BANK_W(BANK_W), .POS_W(POS_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ra_bank(ra_bank), .ra_row(ra_row), .ra_col(ra_col), .ra_shape(ra_shape),
  .ra_count(ra_count), .ra_data(ra_data), .ra_err(ra_err),
  .rb_data(rb_data), .rb_err(rb_err),
  .wr_commit(wr_commit), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
  .wr_shape(wr_shape), .wr_data(wr_data)
);

// File: tb/vrf_matrix_file_test.sv
module vrf_matrix_file_test;

  localparam int NB = 8;
  localparam int D  = 4;
  localparam int W  = 32;
  localparam int L  = D * D;
  localparam int NR = NB * L;
  localparam int BW = L * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] ra_bank, rb_bank, wr_bank, ra_shape, rb_shape, wr_shape;
  logic [2:0] ra_count, rb_count, wr_count;
  logic [1:0] ra_row, ra_col, rb_row, rb_col, wr_row, wr_col;
  logic [BW-1:0] ra_data, rb_data, wr_data;
  logic ra_err, rb_err, wr_err, wr_en;

  vrf_matrix_file uut (
    .clk(clk), .rst_n(rst_n),
    .ra_bank(ra_bank), .ra_row(ra_row), .ra_col(ra_col), .ra_shape(ra_shape),
    .ra_count(ra_count), .ra_data(ra_data), .ra_err(ra_err),
    .rb_bank(rb_bank), .rb_row(rb_row), .rb_col(rb_col), .rb_shape(rb_shape),
    .rb_count(rb_count), .rb_data(rb_data), .rb_err(rb_err),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
    .wr_shape(wr_shape), .wr_count(wr_count), .wr_data(wr_data), .wr_err(wr_err));

  logic [W-1:0] mdl [NR];
  int n_chk = 0;
  int n_fail = 0;

  function automatic int reg_of(int b, int r, int c);
    return (r << 5) | (b << 2) | c;
  endfunction

  function automatic bit exp_err(int sh, int r, int c, int n);
    int er, ec;
    if (sh > 4) return 1'b1;
    if (sh != 0 && (n < 2 || n > 4)) return 1'b1;
    er = (sh == 2 || sh >= 3) ? n : 1;
    ec = (sh == 1 || sh >= 3) ? n : 1;
    return (r + er > 4) || (c + ec > 4);
  endfunction

  // Lane -> register of the access, or -1 when the lane is unused.
  function automatic int lane_reg(int b, int r, int c, int sh, int n, int lane);
    int a, k;
    a = lane / 4;
    k = lane % 4;
    if (exp_err(sh, r, c, n)) return -1;
    case (sh)
      0: return (lane == 0) ? reg_of(b, r, c) : -1;
      1: return (lane < n) ? reg_of(b, r, c + lane) : -1;
      2: return (lane < n) ? reg_of(b, r + lane, c) : -1;
      3: return (a < n && k < n) ? reg_of(b, r + a, c + k) : -1;
      4: return (a < n && k < n) ? reg_of(b, r + k, c + a) : -1;
      default: return -1;
    endcase
  endfunction

  function automatic logic [BW-1:0] exp_read(int b, int r, int c, int sh, int n);
    logic [BW-1:0] v;
    v = '0;
    for (int lane = 0; lane < L; lane++) begin
      int g;
      g = lane_reg(b, r, c, sh, n, lane);
      if (g >= 0) v[lane*W +: W] = mdl[g];
    end
    return v;
  endfunction

  function automatic string tag_of(int sh, bit e);
    if (e) return "R9";
    case (sh)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_vec(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs driven; checks, then commits.
  task automatic run_cycle(string tag);
    bit ea, eb, ew;
    ea = exp_err(ra_shape, ra_row, ra_col, ra_count);
    eb = exp_err(rb_shape, rb_row, rb_col, rb_count);
    ew = exp_err(wr_shape, wr_row, wr_col, wr_count);
    #1;
    check_vec((tag != "") ? tag : tag_of(ra_shape, ea), ra_data,
              exp_read(ra_bank, ra_row, ra_col, ra_shape, ra_count));
    check_bit("R9 port A flag", ra_err, ea);
    check_vec({"R12 ", tag_of(rb_shape, eb)}, rb_data,
              exp_read(rb_bank, rb_row, rb_col, rb_shape, rb_count));
    check_bit("R9 port B flag", rb_err, eb);
    check_bit("R9 write flag", wr_err, ew);
    @(posedge clk);
    #1;
    if (wr_en && !ew) begin
      for (int lane = 0; lane < L; lane++) begin
        int g;
        g = lane_reg(wr_bank, wr_row, wr_col, wr_shape, wr_count, lane);
        if (g >= 0) mdl[g] = wr_data[lane*W +: W];
      end
    end
    @(negedge clk);
  endtask

  task automatic set_a(int b, int r, int c, int sh, int n);
    ra_bank = 3'(b); ra_row = 2'(r); ra_col = 2'(c); ra_shape = 3'(sh); ra_count = 3'(n);
  endtask

  task automatic set_b(int b, int r, int c, int sh, int n);
    rb_bank = 3'(b); rb_row = 2'(r); rb_col = 2'(c); rb_shape = 3'(sh); rb_count = 3'(n);
  endtask

  task automatic set_w(bit en, int b, int r, int c, int sh, int n, logic [BW-1:0] d);
    wr_en = en; wr_bank = 3'(b); wr_row = 2'(r); wr_col = 2'(c);
    wr_shape = 3'(sh); wr_count = 3'(n); wr_data = d;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [BW-1:0] e;
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    set_a(0, 0, 0, 0, 1); set_b(0, 0, 0, 0, 1); set_w(0, 0, 0, 0, 0, 1, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: whole file reads zero after reset
    for (int b = 0; b < NB; b++) begin
      set_a(b, 0, 0, 3, 4); set_b(b, 0, 0, 4, 4);
      run_cycle("R1");
    end

    // R2: fill every register with a value tagged by its flat index
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < D; r++)
        for (int c = 0; c < D; c++) begin
          set_w(1, b, r, c, 0, 0, BW'(32'h1000 + r * 32 + b * 4 + c));
          set_a(b, r, c, 0, 7);
          run_cycle("R2");
        end
    set_w(0, 0, 0, 0, 0, 1, '0);
    for (int b = 0; b < NB; b++) begin
      set_a(b, 0, 0, 3, 4); set_b(b, 0, 0, 2, 4);
      run_cycle("R2");
    end

    // Directed examples with literal expectations
    set_a(0, 1, 0, 1, 3); #1;
    e = '0; e[0 +: W] = 32'h1020; e[W +: W] = 32'h1021; e[2*W +: W] = 32'h1022;
    check_vec("R4 row example", ra_data, e);
    set_a(0, 0, 3, 2, 3); #1;
    e = '0; e[0 +: W] = 32'h1003; e[W +: W] = 32'h1023; e[2*W +: W] = 32'h1043;
    check_vec("R5 column example", ra_data, e);
    set_a(0, 0, 0, 3, 2); #1;
    e = '0; e[0 +: W] = 32'h1000; e[W +: W] = 32'h1001;
    e[4*W +: W] = 32'h1020; e[5*W +: W] = 32'h1021;
    check_vec("R6 matrix example", ra_data, e);
    set_a(0, 0, 0, 4, 2); #1;
    e = '0; e[0 +: W] = 32'h1000; e[W +: W] = 32'h1020;
    e[4*W +: W] = 32'h1001; e[5*W +: W] = 32'h1021;
    check_vec("R7 transposed example", ra_data, e);
    set_a(5, 2, 1, 0, 0); #1;
    e = '0; e[0 +: W] = 32'h1000 + 2 * 32 + 5 * 4 + 1;
    check_vec("R3 scalar ignores count", ra_data, e);
    @(negedge clk);

    // R10: overrunning and malformed writes change nothing
    set_w(1, 3, 0, 2, 1, 3, {L{32'hDEAD_BEEF}}); set_a(3, 0, 0, 3, 4);
    run_cycle("R10");
    set_w(1, 3, 0, 0, 3, 5, {L{32'hDEAD_BEEF}});
    run_cycle("R10");
    set_w(1, 3, 0, 0, 6, 2, {L{32'hDEAD_BEEF}});
    run_cycle("R10");
    set_w(1, 3, 3, 0, 2, 2, {L{32'hDEAD_BEEF}});
    run_cycle("R10");
    set_w(0, 0, 0, 0, 0, 1, '0);
    run_cycle("R10");

    // R8: write 2-wide row with every lane loaded; check the full row
    set_w(1, 4, 1, 1, 1, 2, {L{32'hA5A5_0000}} | BW'(7)); set_a(4, 1, 0, 1, 4);
    run_cycle("R8");
    set_w(0, 0, 0, 0, 0, 1, '0);
    run_cycle("R8");
    set_a(4, 0, 0, 3, 4); run_cycle("R8");

    // R11: same-cycle read returns the old value, then the new one
    set_w(1, 2, 1, 1, 0, 1, BW'(32'hCAFE_F00D)); set_a(2, 1, 1, 0, 1);
    run_cycle("R11");
    set_w(0, 0, 0, 0, 0, 1, '0);
    run_cycle("R11");

    // Constrained random: mixed shapes on all three ports
    for (int it = 0; it < 1500; it++) begin
      int sh[3];
      int n[3];
      logic [BW-1:0] d;
      for (int p = 0; p < 3; p++) begin
        sh[p] = ($urandom_range(0, 9) == 0) ? $urandom_range(5, 7) : $urandom_range(0, 4);
        n[p]  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 7) : $urandom_range(2, 4);
      end
      for (int k = 0; k < L; k++) d[k*W +: W] = $urandom;
      set_w($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
            $urandom_range(0, 3), sh[0], n[0], d);
      set_a($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3), sh[1], n[1]);
      set_b($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 3), sh[2], n[2]);
      run_cycle("");
    end

    finish_run();
  end

endmodule